// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

The arbiter sits between ten vectored interrupt request lines and a CPU core. Each line already carries the OR of all peripheral sources that share its vector. For every line the arbiter applies a per-vector enable and a global enable. It maps a one-bit priority select onto one of three service levels, picks one winner and presents it to the CPU as a registered request. The request comes with the winner's vector index, vector address and level.

Nesting is tracked inside the block with a small level stack. An acknowledge pushes the granted level, and a return-from-interrupt pops it. The top of the stack is the current service level. A new request is only presented when its level lies strictly above that service level. Once presented, the request and its vector stay frozen until the CPU acknowledges them. After that the arbiter re-arbitrates against the new service level.

Top module: `irq_nest_arb`

## Requirements
- R1: While reset is held, `req_o` is 0 and `svc_lvl_o` is 0 (no level in service).
- R2: A vector is presented only if its level is strictly greater than `svc_lvl_o`. Equal or lower levels stay blocked.
- R3: Among eligible vectors, the highest level wins. On equal levels, the lowest vector index wins.
- R4: While `req_o` is 1, `vec_addr_o` equals 3 + 8 × `vec_idx_o`, so index 0 gives 0x03 and index 9 gives 0x4B.
- R5: The level code is 0 for none, 1 for low, 2 for high and 3 for top. A vector whose `prio_hi_i` bit is 0 gets low. With the bit at 1, vectors 0 and 1 get top and vectors 2 to 9 get high. No other level can be assigned.
- R6: `ack_i` while `req_o` is 1 pushes `req_lvl_o` onto the stack. After the edge, `req_o` is 0 and `svc_lvl_o` shows the granted level. `ack_i` with `req_o` at 0 is ignored.
- R7: `reti_i` pops the stack and restores the previous service level, or 0 when the stack empties. `reti_i` on an empty stack is ignored.
- R8: A vector whose `irq_i` bit or `en_i` bit is 0 takes no part in arbitration. With `gie_i` at 0, no vector does.
- R9: While `req_o` is 1 and `ack_i` is 0, `req_o`, `vec_idx_o`, `vec_addr_o` and `req_lvl_o` hold, even when a higher request arrives.
- R10: When `ack_i` (with `req_o` at 1) and `reti_i` fall in the same cycle, the stack top is replaced by the granted level and the depth is unchanged. On an empty stack the granted level is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 10 | Per-vector request lines |
| en_i | input | 10 | Per-vector enables |
| gie_i | input | 1 | Global interrupt enable |
| prio_hi_i | input | 10 | Per-vector level select (0 low, 1 elevated) |
| ack_i | input | 1 | CPU accepts the presented request |
| reti_i | input | 1 | CPU returns from the current handler |
| req_o | output | 1 | Request presented to the CPU |
| vec_idx_o | output | 4 | Index of the presented vector |
| vec_addr_o | output | 17 | Address of the presented vector |
| req_lvl_o | output | 2 | Level of the presented request |
| svc_lvl_o | output | 2 | Current service level (stack top) |

## Verification
The two functions that can coincide are the push from an acknowledge and the pop from a return. The bench builds a one-deep stack at high level, raises a top-level request above it and asserts `ack_i` and `reti_i` in the same cycle. It judges the result by `svc_lvl_o` right after that edge and again after a single further return, which must bring the level back to 0. If the design performed a plain push instead of a replace, the second reading would show high.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LO   = 2'd1,
    LVL_HI   = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;
endpackage

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
  import irq_arb_pkg::*;
#(
  parameter int N_VEC = 10,
  parameter int N_TOP = 2
) (
  input  logic [N_VEC-1:0] irq_i,
  input  logic [N_VEC-1:0] en_i,
  input  logic             gie_i,
  input  logic [N_VEC-1:0] prio_hi_i,
  output lvl_e             lvl_o [N_VEC]
);
  for (genvar g = 0; g < N_VEC; g++) begin : g_vec
    // elevated level depends on vector position
    localparam lvl_e ELEV = (g < N_TOP) ? LVL_TOP : LVL_HI;
    always_comb begin
      if (!(gie_i && en_i[g] && irq_i[g])) lvl_o[g] = LVL_NONE;
      else if (prio_hi_i[g])               lvl_o[g] = ELEV;
      else                                 lvl_o[g] = LVL_LO;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_VEC = 10,
  parameter int IDX_W = $clog2(N_VEC)
) (
  input  lvl_e             lvl_i [N_VEC],
  output lvl_e             best_lvl_o,
  output logic [IDX_W-1:0] best_idx_o
);
  // descending scan with >= lets the lowest index win ties
  always_comb begin
    best_lvl_o = LVL_NONE;
    best_idx_o = '0;
    for (int n = N_VEC - 1; n >= 0; n--) begin
      if (lvl_i[n] != LVL_NONE && lvl_i[n] >= best_lvl_o) begin
        best_lvl_o = lvl_i[n];
        best_idx_o = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_e lvl_i,
  output lvl_e top_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  lvl_e             stk_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
    end else if (push_i && pop_i) begin
      // replace top; depth unchanged unless empty
      if (cnt_q != '0) begin
        stk_q[cnt_q - CNT_ONE] <= lvl_i;
      end else begin
        stk_q[0] <= lvl_i;
        cnt_q    <= CNT_ONE;
      end
    end else if (push_i) begin
      if (cnt_q != CNT_MAX) begin
        stk_q[cnt_q] <= lvl_i;
        cnt_q        <= cnt_q + CNT_ONE;
      end
    end else if (pop_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign top_o = (cnt_q == '0) ? LVL_NONE : stk_q[cnt_q - CNT_ONE];
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int N_VEC      = 10,
  parameter int N_TOP      = 2,
  parameter int DEPTH      = 3,
  parameter int ADDR_W     = 17,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int IDX_W      = $clog2(N_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_VEC-1:0]  irq_i,
  input  logic [N_VEC-1:0]  en_i,
  input  logic              gie_i,
  input  logic [N_VEC-1:0]  prio_hi_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  vec_idx_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        req_lvl_o,
  output logic [1:0]        svc_lvl_o
);
  lvl_e             vec_lvl [N_VEC];
  lvl_e             best_lvl;
  logic [IDX_W-1:0] best_idx;
  lvl_e             svc_lvl;
  logic             accept, ack_ok;

  logic              req_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  lvl_e              lvl_q;

  irq_lvl_map #(.N_VEC(N_VEC), .N_TOP(N_TOP)) u_map (
    .irq_i     (irq_i),
    .en_i      (en_i),
    .gie_i     (gie_i),
    .prio_hi_i (prio_hi_i),
    .lvl_o     (vec_lvl)
  );

  irq_pick #(.N_VEC(N_VEC), .IDX_W(IDX_W)) u_pick (
    .lvl_i      (vec_lvl),
    .best_lvl_o (best_lvl),
    .best_idx_o (best_idx)
  );

  assign ack_ok = ack_i && req_q;
  assign accept = (best_lvl != LVL_NONE) && (best_lvl > svc_lvl);

  irq_lvl_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (ack_ok),
    .pop_i  (reti_i),
    .lvl_i  (lvl_q),
    .top_o  (svc_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
      lvl_q  <= LVL_NONE;
    end else if (ack_ok) begin
      req_q <= 1'b0;
    end else if (!req_q && accept) begin
      req_q  <= 1'b1;
      idx_q  <= best_idx;
      lvl_q  <= best_lvl;
      addr_q <= ADDR_W'(VEC_BASE) + ADDR_W'(best_idx) * ADDR_W'(VEC_STRIDE);
    end
  end

  assign req_o      = req_q;
  assign vec_idx_o  = idx_q;
  assign vec_addr_o = addr_q;
  assign req_lvl_o  = lvl_q;
  assign svc_lvl_o  = svc_lvl;
endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int N_VEC      = 10,
  parameter int N_TOP      = 2,
  parameter int ADDR_W     = 17,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int IDX_W      = $clog2(N_VEC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_VEC-1:0]  irq_i,
  input logic              gie_i,
  input logic              ack_i,
  input logic              reti_i,
  input logic              req_o,
  input logic [IDX_W-1:0]  vec_idx_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [1:0]        req_lvl_o,
  input logic [1:0]        svc_lvl_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> !req_o && svc_lvl_o == 2'd0);

  // R2
  above_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> req_lvl_o > svc_lvl_o);

  // R4
  vec_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> vec_addr_o == ADDR_W'(VEC_BASE) + ADDR_W'(vec_idx_o) * ADDR_W'(VEC_STRIDE));

  // R5
  lvl_allowed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (32'(vec_idx_o) < N_TOP) ? (req_lvl_o == 2'd3 || req_lvl_o == 2'd1)
                                       : (req_lvl_o == 2'd2 || req_lvl_o == 2'd1));

  // R6
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !reti_i |=> !req_o && svc_lvl_o == $past(req_lvl_o));

  // R7
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !(req_o && ack_i) && svc_lvl_o == 2'd0 |=> svc_lvl_o == 2'd0);

  // R8
  gie_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_i || irq_i == '0) && !req_o |=> !req_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(vec_idx_o) && $stable(req_lvl_o) && $stable(vec_addr_o));

  // R10
  swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && reti_i |=> svc_lvl_o == $past(req_lvl_o));
endmodule

bind irq_nest_arb irq_nest_arb_chk #(
  .N_VEC(N_VEC), .N_TOP(N_TOP), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .gie_i      (gie_i),
  .ack_i      (ack_i),
  .reti_i     (reti_i),
  .req_o      (req_o),
  .vec_idx_o  (vec_idx_o),
  .vec_addr_o (vec_addr_o),
  .req_lvl_o  (req_lvl_o),
  .svc_lvl_o  (svc_lvl_o)
);

// File: tb/test_irq_nest_arb.sv
module test_irq_nest_arb;
  localparam int NV = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NV-1:0] irq_i = '0, en_i = '0, prio_hi_i = '0;
  logic          gie_i = 1'b0, ack_i = 1'b0, reti_i = 1'b0;
  logic          req_o;
  logic [3:0]    vec_idx_o;
  logic [16:0]   vec_addr_o;
  logic [1:0]    req_lvl_o, svc_lvl_o;

  always #2 clk_i = ~clk_i;

  irq_nest_arb i_irq_nest_arb (
    .clk_i, .rst_ni, .irq_i, .en_i, .gie_i, .prio_hi_i, .ack_i, .reti_i,
    .req_o, .vec_idx_o, .vec_addr_o, .req_lvl_o, .svc_lvl_o
  );

  typedef struct {
    logic  req;
    int    idx;
    int    lvl;
    int    svc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0;
  bit   done = 0;

  // reference state after the last edge
  logic m_req = 0;
  int   m_idx = 0, m_lvl = 0;
  int   m_stk[$];

  function automatic int vlvl(int n, logic [NV-1:0] irq, logic [NV-1:0] en, logic gie, logic [NV-1:0] pr);
    if (!gie || !en[n] || !irq[n]) return 0;
    if (!pr[n]) return 1;
    return (n < 2) ? 3 : 2;
  endfunction

  task automatic step(input logic [NV-1:0] irq, input logic [NV-1:0] en, input logic gie,
                      input logic [NV-1:0] pr, input logic ack, input logic reti, input string tag);
    int svc, best, bidx;
    logic ack_ok;
    exp_t e;
    @(negedge clk_i);
    irq_i = irq; en_i = en; gie_i = gie; prio_hi_i = pr; ack_i = ack; reti_i = reti;
    svc = (m_stk.size() == 0) ? 0 : m_stk[$];
    ack_ok = ack && m_req;
    best = 0; bidx = 0;
    for (int n = 0; n < NV; n++) begin
      int l = vlvl(n, irq, en, gie, pr);
      if (l > best) begin best = l; bidx = n; end
    end
    // stack update uses the level held before the edge
    if (ack_ok && reti) begin
      if (m_stk.size() > 0) m_stk[m_stk.size()-1] = m_lvl; else m_stk.push_back(m_lvl);
    end else if (ack_ok) begin
      if (m_stk.size() < 3) m_stk.push_back(m_lvl);
    end else if (reti) begin
      if (m_stk.size() > 0) void'(m_stk.pop_back());
    end
    if (ack_ok) m_req = 0;
    else if (!m_req && best > svc) begin m_req = 1; m_idx = bidx; m_lvl = best; end
    e.req = m_req; e.idx = m_idx; e.lvl = m_lvl;
    e.svc = (m_stk.size() == 0) ? 0 : m_stk[$];
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        n_chk++;
        ok = (req_o == e.req) && (int'(svc_lvl_o) == e.svc);
        if (e.req) ok = ok && int'(vec_idx_o) == e.idx && int'(req_lvl_o) == e.lvl
                           && int'(vec_addr_o) == 3 + 8 * e.idx;
        if (!ok) begin
          n_err++;
          $display("FAIL %s: got req=%0b idx=%0d addr=%0h lvl=%0d svc=%0d exp req=%0b idx=%0d addr=%0h lvl=%0d svc=%0d",
                   e.tag, req_o, vec_idx_o, vec_addr_o, req_lvl_o, svc_lvl_o,
                   e.req, e.idx, 3 + 8 * e.idx, e.lvl, e.svc);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  localparam logic [NV-1:0] ALL = '1;

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (req_o !== 1'b0 || svc_lvl_o !== 2'd0) begin
      n_err++;
      $display("FAIL R1: got req=%0b svc=%0d exp req=0 svc=0", req_o, svc_lvl_o);
    end
    rst_ni = 1'b1;

    step(10'h020, ALL, 1, 10'h000, 0, 0, "R5 low on vec5, R4 addr 0x2B");
    step(10'h020, ALL, 1, 10'h000, 1, 0, "R6 push low");
    step(10'h020, ALL, 1, 10'h000, 0, 0, "R2 equal low blocked");
    step(10'h024, ALL, 1, 10'h004, 0, 0, "R3 high vec2 over low");
    step(10'h024, ALL, 1, 10'h004, 1, 0, "R6 push high");
    step(10'h080, ALL, 1, 10'h080, 0, 0, "R2 equal high blocked");
    step(10'h081, ALL, 1, 10'h081, 0, 0, "R5 top on vec0");
    step(10'h081, ALL, 1, 10'h081, 1, 0, "R6 push top, full depth");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R7 pop to high");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R7 pop to low");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R7 pop to none");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R7 pop on empty ignored");
    step(10'h108, ALL, 1, 10'h108, 0, 0, "R3 tie high picks vec3");
    step(10'h109, ALL, 1, 10'h109, 0, 0, "R9 hold despite top request");
    step(10'h109, ALL, 1, 10'h109, 0, 0, "R9 hold second cycle");
    step(10'h109, ALL, 1, 10'h109, 1, 0, "R6 push high vec3");
    step(10'h109, ALL, 1, 10'h109, 0, 0, "R3 top over high after ack");
    step(10'h000, ALL, 1, 10'h000, 1, 1, "R10 ack and return together");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R10 depth unchanged, pop to none");
    step(10'h010, ALL, 0, 10'h000, 0, 0, "R8 global enable off");
    step(10'h010, ALL & ~10'h010, 1, 10'h000, 0, 0, "R8 per-vector enable off");
    step(10'h210, ALL, 1, 10'h200, 0, 0, "R3 high vec9 over low vec4, R4 addr 0x4B");
    step(10'h000, ALL, 1, 10'h000, 1, 0, "R6 push high vec9");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R7 pop to none");
    step(10'h000, ALL, 1, 10'h000, 1, 0, "R6 stray ack ignored");
    step(10'h006, ALL, 1, 10'h006, 0, 0, "R5 top on vec1 over high vec2");
    step(10'h006, ALL, 1, 10'h006, 1, 0, "R6 push top vec1");
    step(10'h000, ALL, 1, 10'h000, 0, 1, "R7 pop to none");
    step(10'h300, ALL, 1, 10'h000, 0, 0, "R3 tie low picks vec8");
    step(10'h000, ALL, 1, 10'h000, 0, 0, "R9 hold after line drops");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule